// File: doc/BRIEF.md
# Split-Tag Two-Phase Instruction Cache Lookup

This block performs the lookup of a 2-way set-associative instruction cache of 8 KB with 16-byte lines and 32-bit addresses. Each access finishes within one clock and uses both clock edges. At the rising edge the request address is taken in. A narrow partial tag (the three low tag bits plus a valid bit) is then compared in both ways. On the falling edge the full-tag store and the data store are read only in the ways whose partial tag matched. The hit flag, hit way and selected 32-bit word are registered there.

Three 2-bit counts report, for every access, how many partial-tag, full-tag and data arrays were enabled. Power-aware logic or a testbench can compare the enable pattern with the partial-tag outcome. A refill port writes a whole line into the way that a one-bit-per-set LRU names as the victim.

Top module: `stc_lookup`

## Requirements
- R1: Address fields: byte offset addr[3:0], word select addr[3:2], set index addr[11:4], tag addr[31:12], partial tag addr[14:12], remaining tag addr[31:15].
- R2: After reset every line is invalid, and an invalid line never counts as a partial-tag match.
- R3: When no way matches on the partial tag, the access is a miss with counts (partial, full, data) = (2,0,0).
- R4: When exactly one way matches on the partial tag, the counts are (2,1,1), and the access hits only if that way's remaining tag also matches.
- R5: When both ways match on the partial tag, the counts are (2,2,2), and the full compare picks the hit way or reports a miss.
- R6: A partial-tag match with a remaining-tag mismatch is a miss, and rsp_data is 0 on every miss.
- R7: A request present at a rising edge is answered on the falling edge of the same cycle. In a cycle without an accepted request, rsp_valid is 0 and all three counts are 0.
- R8: On a hit, rsp_way gives the way (0 or 1) and rsp_data gives word addr[3:2] of the line, where word i is fill_line bits [32i+31:32i].
- R9: A refill writes the way that the set's LRU bit names. That bit is 0 after reset and afterwards names the way not most recently hit or refilled, a hit reported just before the refill included.
- R10: When fill_valid and req_valid are high at the same edge, the refill is performed and the request is dropped (no response).
- R11: While rst_n is low, rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge takes requests and refills, falling edge registers responses |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Lookup byte address |
| fill_valid | input | 1 | Refill request |
| fill_addr | input | 32 | Address of the line being refilled |
| fill_line | input | 128 | Line contents, word i at bits [32i+31:32i] |
| rsp_valid | output | 1 | Response for the request of this cycle |
| rsp_hit | output | 1 | Full tag matched in some way |
| rsp_way | output | 1 | Hit way |
| rsp_data | output | 32 | Selected word, 0 on miss |
| act_pre | output | 2 | Partial-tag arrays enabled |
| act_full | output | 2 | Full-tag arrays enabled |
| act_data | output | 2 | Data arrays enabled |

## Verification
The bench builds the block with its default geometry: 2 ways, 256 sets, 16-byte lines and a 3-bit partial tag. With a 3-bit partial tag, tags that share their low three bits and differ above them are easy to choose. This makes the single-match mismatch and the double-match cases reachable in a few directed cycles. A randomized phase confines traffic to four sets and a handful of tags, so that evictions, LRU flips right after hits and all four enable patterns occur often against the behavioural model.

// File: rtl/stc_pkg.sv
package stc_pkg;
    parameter int ADDR_W = 32;
    parameter int LINE_B = 16;
    parameter int SETS   = 256;
    parameter int WAYS   = 2;
    parameter int PRE_W  = 3;
    parameter int WORD_W = 32;

    localparam int OFF_W  = $clog2(LINE_B);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int REST_W = TAG_W - PRE_W;
    localparam int WPL    = LINE_B / (WORD_W / 8);
    localparam int WSEL_W = $clog2(WPL);
    localparam int LINE_W = LINE_B * 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int CNT_W  = $clog2(WAYS + 1);
    localparam int BSEL_LO = OFF_W - WSEL_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [PRE_W-1:0]  pre_t;
    typedef logic [REST_W-1:0] rest_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // rising-edge stage: accepted request and partial-tag result
    typedef struct packed {
        logic            v;
        addr_t           addr;
        logic [WAYS-1:0] pm;
    } ph1_t;

    // falling-edge stage: registered response
    typedef struct packed {
        logic             v;
        logic             hit;
        logic [WAY_W-1:0] way;
        idx_t             idx;
        word_t            data;
        cnt_t             npre;
        cnt_t             nfull;
        cnt_t             ndata;
    } ph2_t;

    function automatic idx_t idx_of(addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction
    function automatic pre_t pre_of(addr_t a);
        return a[OFF_W + IDX_W +: PRE_W];
    endfunction
    function automatic rest_t rest_of(addr_t a);
        return a[OFF_W + IDX_W + PRE_W +: REST_W];
    endfunction
    function automatic wsel_t wsel_of(addr_t a);
        return a[BSEL_LO +: WSEL_W];
    endfunction
endpackage

// File: rtl/stc_pretag_bank.sv
module stc_pretag_bank
    import stc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  pre_t wr_pre,
    input  idx_t rd_idx,
    input  pre_t rd_pre,
    output logic match
);
    logic [SETS-1:0] valid_q;
    logic [SETS-1:0] valid_d;
    pre_t            pre_q [SETS];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) pre_q[wr_idx] <= wr_pre;
    end

    assign match = valid_q[rd_idx] && (pre_q[rd_idx] == rd_pre);

    // R2: no line can match before it has been written once since reset
    assert_invalid_after_reset_R2: assert property (@(posedge clk)
        $rose(rst_n) |-> !match);
endmodule

// File: rtl/stc_full_bank.sv
module stc_full_bank
    import stc_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  rest_t wr_rest,
    input  line_t wr_line,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    input  rest_t rd_rest,
    input  wsel_t rd_wsel,
    output logic  tag_eq,
    output word_t rd_word
);
    rest_t rest_q [SETS];
    line_t line_q [SETS];
    line_t line_sel;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rest_q[wr_idx] <= wr_rest;
            line_q[wr_idx] <= wr_line;
        end
    end

    // arrays are only read when the partial tag selected this way
    always_comb begin
        line_sel = rd_en ? line_q[rd_idx] : '0;
        tag_eq   = rd_en && (rest_q[rd_idx] == rd_rest);
        rd_word  = line_sel[rd_wsel * WORD_W +: WORD_W];
    end
endmodule

// File: rtl/stc_lru.sv
module stc_lru
    import stc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_v,
    input  idx_t             upd_idx,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             fill_v,
    input  idx_t             fill_idx,
    output logic [WAY_W-1:0] victim
);
    logic [SETS-1:0] lru_q;
    logic [SETS-1:0] lru_d;

    // a hit reported on the previous falling edge is forwarded to the refill
    always_comb begin
        if (upd_v && upd_idx == fill_idx) victim = ~upd_way;
        else                              victim = lru_q[fill_idx];
    end

    always_comb begin
        lru_d = lru_q;
        if (upd_v)  lru_d[upd_idx]  = ~upd_way;
        if (fill_v) lru_d[fill_idx] = ~victim;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lru_q <= '0;
        else        lru_q <= lru_d;
    end

    // R9: after a refill the set's LRU bit names the other way
    assert_lru_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_v |=> lru_q[$past(fill_idx)] != $past(victim));
endmodule

// File: rtl/stc_lookup.sv
module stc_lookup
    import stc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        fill_valid,
    input  logic [31:0] fill_addr,
    input  logic [127:0] fill_line,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_way,
    output logic [31:0] rsp_data,
    output logic [1:0]  act_pre,
    output logic [1:0]  act_full,
    output logic [1:0]  act_data
);
    ph1_t ph1_d, ph1_q;
    ph2_t ph2_d, ph2_q;

    logic [WAYS-1:0]  pm_w;
    logic [WAYS-1:0]  teq_w;
    word_t            word_w [WAYS];
    logic [WAY_W-1:0] victim;

    idx_t fidx;
    assign fidx = idx_of(fill_addr);

    stc_lru i_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_v    (ph2_q.v && ph2_q.hit),
        .upd_idx  (ph2_q.idx),
        .upd_way  (ph2_q.way),
        .fill_v   (fill_valid),
        .fill_idx (fidx),
        .victim   (victim)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic wr_w;
        assign wr_w = fill_valid && (victim == WAY_W'(w));

        stc_pretag_bank i_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_w),
            .wr_idx (fidx),
            .wr_pre (pre_of(fill_addr)),
            .rd_idx (idx_of(req_addr)),
            .rd_pre (pre_of(req_addr)),
            .match  (pm_w[w])
        );

        stc_full_bank i_full (
            .clk     (clk),
            .wr_en   (wr_w),
            .wr_idx  (fidx),
            .wr_rest (rest_of(fill_addr)),
            .wr_line (fill_line),
            .rd_en   (ph1_q.v && ph1_q.pm[w]),
            .rd_idx  (idx_of(ph1_q.addr)),
            .rd_rest (rest_of(ph1_q.addr)),
            .rd_wsel (wsel_of(ph1_q.addr)),
            .tag_eq  (teq_w[w]),
            .rd_word (word_w[w])
        );
    end

    // rising-edge phase: a refill takes precedence over a lookup
    always_comb begin
        ph1_d      = ph1_q;
        ph1_d.v    = req_valid && !fill_valid;
        ph1_d.addr = req_addr;
        ph1_d.pm   = pm_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph1_q <= '0;
        else        ph1_q <= ph1_d;
    end

    // falling-edge phase: confirm the hit in the selected ways only
    always_comb begin
        ph2_d = '0;
        if (ph1_q.v) begin
            ph2_d.v    = 1'b1;
            ph2_d.idx  = idx_of(ph1_q.addr);
            ph2_d.npre = CNT_W'(WAYS);
            for (int w = 0; w < WAYS; w++) begin
                if (ph1_q.pm[w]) begin
                    ph2_d.nfull = ph2_d.nfull + 1'b1;
                    ph2_d.ndata = ph2_d.ndata + 1'b1;
                end
            end
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (teq_w[w]) begin
                    ph2_d.hit  = 1'b1;
                    ph2_d.way  = WAY_W'(w);
                    ph2_d.data = word_w[w];
                end
            end
        end
    end

    always_ff @(negedge clk) begin
        if (!rst_n) ph2_q <= '0;
        else        ph2_q <= ph2_d;
    end

    assign rsp_valid = ph2_q.v;
    assign rsp_hit   = ph2_q.hit;
    assign rsp_way   = ph2_q.way;
    assign rsp_data  = ph2_q.data;
    assign act_pre   = ph2_q.npre;
    assign act_full  = ph2_q.nfull;
    assign act_data  = ph2_q.ndata;

    // R7: no activity is reported without a response
    assert_idle_quiet_R7: assert property (@(negedge clk) disable iff (!rst_n)
        !rsp_valid |-> (act_pre == 0 && act_full == 0 && act_data == 0 && !rsp_hit));
    // R3: every answered access reads both partial tags
    assert_pre_both_R3: assert property (@(negedge clk) disable iff (!rst_n)
        rsp_valid |-> act_pre == 2'd2);
    // R4: full-tag and data arrays are enabled in the same ways
    assert_full_data_pair_R4: assert property (@(negedge clk) disable iff (!rst_n)
        act_full == act_data);
    // R6: a hit needs at least one full-tag read; a miss returns zero data
    assert_hit_needs_full_R6: assert property (@(negedge clk) disable iff (!rst_n)
        rsp_hit |-> act_full != 2'd0);
    assert_miss_zero_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_data == '0);
    // R10: a refill at a rising edge leaves no response for that cycle
    assert_fill_drops_req_R10: assert property (@(negedge clk) disable iff (!rst_n)
        $past(fill_valid) |-> !rsp_valid);
endmodule

// File: tb/test_stc_lookup.sv
`timescale 1ns/1ps
module test_stc_lookup;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [127:0] fill_line = '0;
    logic rsp_valid, rsp_hit, rsp_way;
    logic [31:0] rsp_data;
    logic [1:0] act_pre, act_full, act_data;

    always #2 clk = ~clk;

    stc_lookup i_stc_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_data(rsp_data), .act_pre(act_pre), .act_full(act_full),
        .act_data(act_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural model: per way and set
    bit          m_v   [2][256];
    int unsigned m_tag [2][256];
    logic [127:0] m_line [2][256];
    bit          m_lru [256];

    bit e_valid, e_hit, e_way;
    int unsigned e_data, e_pre, e_full, e_data_cnt;

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int unsigned tag, int unsigned idx, int unsigned w);
        return {tag[19:0], idx[7:0], w[1:0], 2'b00};
    endfunction

    function automatic logic [127:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // one cycle: inputs set now, checked after the falling edge of the next cycle
    task automatic cycle(bit rv, logic [31:0] ra, bit fv, logic [31:0] fa, logic [127:0] fl);
        int unsigned idx, tag, nm;
        bit m0, m1, h0, h1;
        idx = ra[11:4];
        tag = ra[31:12];
        e_valid = rv && !fv;
        e_hit = 0; e_way = 0; e_data = 0; e_pre = 0; e_full = 0; e_data_cnt = 0;
        if (e_valid) begin
            m0 = m_v[0][idx] && (m_tag[0][idx][2:0] == tag[2:0]);
            m1 = m_v[1][idx] && (m_tag[1][idx][2:0] == tag[2:0]);
            h0 = m0 && m_tag[0][idx] == tag;
            h1 = m1 && m_tag[1][idx] == tag;
            nm = int'(m0) + int'(m1);
            e_pre = 2; e_full = nm; e_data_cnt = nm;
            if (h0 || h1) begin
                e_hit = 1;
                e_way = h0 ? 1'b0 : 1'b1;
                e_data = m_line[e_way][idx][32*ra[3:2] +: 32];
                m_lru[idx] = ~e_way;
            end
        end
        if (fv) begin
            int unsigned fi;
            bit vic;
            fi = fa[11:4];
            vic = m_lru[fi];
            m_v[vic][fi] = 1;
            m_tag[vic][fi] = fa[31:12];
            m_line[vic][fi] = fl;
            m_lru[fi] = ~vic;
        end
        req_valid = rv; req_addr = ra; fill_valid = fv; fill_addr = fa; fill_line = fl;
        @(posedge clk);
        #3;
        req_valid = 0; fill_valid = 0;
        chk(fv ? "R10 rsp_valid" : "R7 rsp_valid", rsp_valid, e_valid);
        if (e_valid) begin
            chk("R4 rsp_hit", rsp_hit, e_hit);
            if (e_hit) chk("R8 rsp_way", rsp_way, e_way);
            chk(e_hit ? "R8 rsp_data" : "R6 rsp_data", rsp_data, e_data);
            chk("R3 act_pre", act_pre, e_pre);
            chk(e_full == 0 ? "R3 act_full" : (e_full == 1 ? "R4 act_full" : "R5 act_full"),
                act_full, e_full);
            chk("R5 act_data", act_data, e_data_cnt);
        end else begin
            chk("R7 act_pre idle", act_pre, 0);
            chk("R7 act_full idle", act_full, 0);
        end
    endtask

    task automatic req(logic [31:0] a); cycle(1, a, 0, '0, '0); endtask
    task automatic fill(logic [31:0] a); cycle(0, '0, 1, a, rnd_line()); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(posedge clk); #3;
        // R1 R2 R3: empty cache, no partial match
        req(mk(20'h00011, 5, 0));
        // R9: first refill goes to way 0
        fill(mk(20'h00011, 5, 0));
        // R4 R8: single match and hit, word 2
        req(mk(20'h00011, 5, 2));
        // R6: same partial tag, other remaining tag
        req(mk(20'h00111, 5, 1));
        // R9: LRU now names way 1
        fill(mk(20'h00111, 5, 0));
        // R5: both ways match on the partial tag
        req(mk(20'h00111, 5, 3));
        req(mk(20'h00211, 5, 0));
        // R3: valid lines, other partial tag
        req(mk(20'h00012, 5, 1));
        // R9: hit on way 0 just before the refill forces victim way 1
        req(mk(20'h00011, 5, 0));
        fill(mk(20'h00211, 5, 0));
        req(mk(20'h00111, 5, 0));
        req(mk(20'h00211, 5, 1));
        req(mk(20'h00011, 5, 3));
        // R10: simultaneous refill and lookup
        cycle(1, mk(20'h00011, 5, 0), 1, mk(20'h00012, 6, 0), rnd_line());
        req(mk(20'h00012, 6, 2));
        // R7: idle cycle
        cycle(0, '0, 0, '0, '0);
        // randomized traffic on four sets and a few tags
        for (int i = 0; i < 600; i++) begin
            int unsigned t, s, kind;
            logic [31:0] a;
            t = ($urandom % 6) * 8 + ($urandom % 2);
            s = $urandom % 4;
            a = mk(t, s, $urandom % 4);
            kind = $urandom % 4;
            if (kind == 0 && !((m_v[0][s] && m_tag[0][s] == t) || (m_v[1][s] && m_tag[1][s] == t)))
                fill(a);
            else if (kind == 1)
                cycle(0, '0, 0, '0, '0);
            else
                req(a);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule